// File: doc/BRIEF.md
# State-Enable CSR Access Gate

This block holds the index-0 state-enable control registers of a hart at three privilege tiers: machine, hypervisor and supervisor. It decodes CSR read and write requests from the 12-bit CSR address, the current privilege level and the virtualization flag. For each request it returns read data, or it flags an illegal-instruction fault or a virtual-instruction fault. Writes commit on the clock edge that ends the request cycle. Read data and fault flags are combinational in the request cycle.

The block also drives one enable per controlled resource at the current privilege level. The resources are custom state, the floating-point control/status register, the jump-vector-table CSR, the environment-configuration CSRs, indirect-CSR state, interrupt-file state, advanced-interrupt state and context CSRs. The instruction decoder and the extension units use these enables. From the same enables the block flags which floating-point instructions must trap when floating point runs on the integer registers.

A lower tier always sees its own bits ANDed with the matching bits of every tier above it. The top bit of each higher-tier register decides whether the lower-tier register can be reached at all.

Top module: `stateen_gate`

## Requirements
- R1: After reset every stored bit is zero. Reads of all three registers from machine mode return zero, and every enable below machine mode is zero.
- R2: The block claims (csr_hit_o) only 0x30C (machine), 0x60C (hypervisor, when present) and 0x10C (supervisor). In the 32-bit configuration it also claims 0x31C and 0x61C, which carry bits 63:32 of the machine and hypervisor registers. Any other address, including 0x31C/0x61C in the 64-bit configuration, is not claimed, raises no fault and reads zero.
- R3: The machine register is reachable only in machine mode. Any other mode, virtualized or not, gets an illegal-instruction fault.
- R4: Bit 63 of the machine register gates the hypervisor and supervisor registers. When it is 0, a non-virtualized S-mode access to either register and any virtualized access get an illegal-instruction fault. Non-virtualized U-mode never reaches either register.
- R5: With machine bit 63 set, the following get a virtual-instruction fault: a VS- or VU-mode access to the hypervisor register, a VS-mode access to the supervisor register when hypervisor bit 63 is 0, and any VU-mode access to the supervisor register. The two fault flags are never both set.
- R6: These bit positions are stored: machine bits 0,1,2,56,57,58,59,60,62,63; hypervisor bits 0,1,2,57,58,59,60,62,63; supervisor bits 0,1,2. All other bits read zero. Hypervisor bit 63 is always writable.
- R7: A hypervisor bit reads as itself ANDed with the machine bit at the same position. A supervisor bit reads as itself ANDed with the machine bit and, when the hypervisor tier is present, with the hypervisor bit.
- R8: While misa_f_i is 1, bit 1 of the machine register is read-only zero. A machine write in that state clears it, so it also reads zero in the lower tiers.
- R9: When misa_f_i is 0 and bit 1 is clear at the current level, every floating-point instruction below machine mode faults. The fault is virtual-instruction (fp_virtual_o) when the mode is virtualized, the machine bit is 1 and the hypervisor bit is 0; otherwise it is illegal-instruction (fp_illegal_o).
- R10: Enables at the current level are as follows. In machine mode all are 1. In HS mode they are the machine bits. In U mode they are the machine bits, with bits 0..2 also ANDed with the supervisor bits. In VS mode they are the machine-and-hypervisor bits, and in VU mode the same with bits 0..2 also ANDed with the supervisor bits. Bit positions: custom 0, fcsr 1, jvt 2, context 57, interrupt-file 58, advanced-interrupt 59, indirect-CSR 60, envcfg 62.
- R11: A faulted access writes nothing and returns zero read data.
- R12: In the 32-bit configuration, 0x30C and 0x60C carry bits 31:0, and the high-half addresses carry bits 63:32, for both read and write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_valid_i | input | 1 | CSR request present this cycle |
| csr_we_i | input | 1 | Request is a write |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | XLEN | Write data |
| priv_i | input | 2 | Current privilege: 0 U, 1 S, 3 M |
| virt_i | input | 1 | Virtualized mode (VS/VU) |
| misa_f_i | input | 1 | Floating point uses its own register file |
| csr_hit_o | output | 1 | Address belongs to this block |
| csr_rdata_o | output | XLEN | Read data, zero when faulted |
| csr_illegal_o | output | 1 | Illegal-instruction fault |
| csr_virtual_o | output | 1 | Virtual-instruction fault |
| en_custom_o | output | 1 | Custom state accessible |
| en_fcsr_o | output | 1 | fcsr accessible |
| en_jvt_o | output | 1 | Jump-vector-table CSR accessible |
| en_envcfg_o | output | 1 | Environment-configuration CSRs accessible |
| en_csrind_o | output | 1 | Indirect-CSR state accessible |
| en_imsic_o | output | 1 | Interrupt-file state accessible |
| en_aia_o | output | 1 | Advanced-interrupt state accessible |
| en_context_o | output | 1 | Context CSRs accessible |
| fp_illegal_o | output | 1 | Floating-point instructions raise illegal-instruction |
| fp_virtual_o | output | 1 | Floating-point instructions raise virtual-instruction |

## Verification
Assertions check on every cycle that unused bits are never stored, that a lower tier never reads a bit its higher tier lacks, that the two fault kinds are exclusive, that faulted writes leave the state untouched, and that machine mode sees every enable open. Only the bench scenarios can show the full fault table over all tier/mode/bit-63 combinations with the right read values. The same holds for the per-mode enable vectors under mixed bit patterns, the way fcsr behaves across a misa change, and the half-register mapping of the 32-bit configuration.

// File: rtl/stateen_pkg.sv
`timescale 1ns/1ps
package stateen_pkg;
  localparam int BIT_CUSTOM  = 0;
  localparam int BIT_FCSR    = 1;
  localparam int BIT_JVT     = 2;
  localparam int BIT_P1P13   = 56;
  localparam int BIT_CONTEXT = 57;
  localparam int BIT_IMSIC   = 58;
  localparam int BIT_AIA     = 59;
  localparam int BIT_CSRIND  = 60;
  localparam int BIT_ENVCFG  = 62;
  localparam int BIT_SE0     = 63;

  localparam logic [63:0] M_WMASK = 64'hDF00_0000_0000_0007;
  localparam logic [63:0] H_WMASK = 64'hDE00_0000_0000_0007;
  localparam logic [31:0] S_WMASK = 32'h0000_0007;

  localparam logic [11:0] ADDR_M    = 12'h30C;
  localparam logic [11:0] ADDR_M_HI = 12'h31C;
  localparam logic [11:0] ADDR_H    = 12'h60C;
  localparam logic [11:0] ADDR_H_HI = 12'h61C;
  localparam logic [11:0] ADDR_S    = 12'h10C;

  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_S = 2'b01;
  localparam logic [1:0] PRIV_M = 2'b11;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_M_LO, SEL_M_HI, SEL_H_LO, SEL_H_HI, SEL_S
  } sel_e;

  typedef struct packed {
    logic custom;
    logic fcsr;
    logic jvt;
    logic envcfg;
    logic csrind;
    logic imsic;
    logic aia;
    logic ctx;
  } gate_t;

  function automatic gate_t pick_gates(input logic [63:0] v);
    gate_t g;
    g.custom = v[BIT_CUSTOM];
    g.fcsr   = v[BIT_FCSR];
    g.jvt    = v[BIT_JVT];
    g.envcfg = v[BIT_ENVCFG];
    g.csrind = v[BIT_CSRIND];
    g.imsic  = v[BIT_IMSIC];
    g.aia    = v[BIT_AIA];
    g.ctx    = v[BIT_CONTEXT];
    return g;
  endfunction
endpackage

// File: rtl/stateen_decode.sv
`timescale 1ns/1ps
module stateen_decode
  import stateen_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int HAS_H = 1
) (
  input  logic        valid_i,
  input  logic [11:0] addr_i,
  input  logic [1:0]  priv_i,
  input  logic        virt_i,
  input  logic        m_se0_i,
  input  logic        h_se0_i,
  output sel_e        sel_o,
  output logic        hit_o,
  output logic        illegal_o,
  output logic        virtual_o
);
  localparam bit HI_HALVES = (XLEN == 32);
  localparam bit HYP       = (HAS_H != 0);

  logic is_m, is_s, is_u, vmode, ill, vf;

  assign is_m  = (priv_i == PRIV_M);
  assign is_s  = (priv_i == PRIV_S);
  assign is_u  = (priv_i == PRIV_U);
  assign vmode = HYP && virt_i && (is_s || is_u);

  always_comb begin
    sel_o = SEL_NONE;
    if (addr_i == ADDR_M)                              sel_o = SEL_M_LO;
    else if (HI_HALVES && addr_i == ADDR_M_HI)         sel_o = SEL_M_HI;
    else if (HYP && addr_i == ADDR_H)                  sel_o = SEL_H_LO;
    else if (HYP && HI_HALVES && addr_i == ADDR_H_HI)  sel_o = SEL_H_HI;
    else if (addr_i == ADDR_S)                         sel_o = SEL_S;
  end

  always_comb begin
    ill = 1'b0;
    vf  = 1'b0;
    unique case (sel_o)
      SEL_M_LO, SEL_M_HI: ill = !is_m;
      SEL_H_LO, SEL_H_HI: begin
        if (is_m)                 ill = 1'b0;
        else if (vmode)           begin ill = !m_se0_i; vf = m_se0_i; end
        else if (is_s)            ill = !m_se0_i;
        else                      ill = 1'b1;
      end
      SEL_S: begin
        if (is_m)                 ill = 1'b0;
        else if (vmode && is_s)   begin ill = !m_se0_i; vf = m_se0_i && !h_se0_i; end
        else if (vmode)           begin ill = !m_se0_i; vf = m_se0_i; end
        else if (is_s)            ill = !m_se0_i;
        else                      ill = 1'b1;
      end
      default: ;
    endcase
  end

  assign hit_o     = valid_i && (sel_o != SEL_NONE);
  assign illegal_o = hit_o && ill;
  assign virtual_o = hit_o && vf;
endmodule

// File: rtl/stateen_regs.sv
`timescale 1ns/1ps
module stateen_regs
  import stateen_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int HAS_H = 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  sel_e            sel_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic            misa_f_i,
  output logic [XLEN-1:0] rdata_o,
  output logic            m_se0_o,
  output logic            h_se0_o,
  output gate_t           m_gate_o,
  output gate_t           h_gate_o,
  output logic [2:0]      s_low_o
);
  localparam logic [63:0] FCSR_BIT = 64'd1 << BIT_FCSR;
  localparam bit          HYP      = (HAS_H != 0);

  logic [63:0] m_q, h_q, m_d, h_d, wd64, m_wmask, m_eff, h_eff, rd64;
  logic [31:0] s_q, s_eff;

  assign wd64    = 64'(wdata_i);
  assign m_wmask = M_WMASK & ~(misa_f_i ? FCSR_BIT : 64'd0);

  always_comb begin
    m_d = m_q;
    h_d = h_q;
    case (sel_i)
      SEL_M_LO: if (XLEN == 64) m_d = wd64; else m_d[31:0] = wd64[31:0];
      SEL_M_HI: m_d[63:32] = wd64[31:0];
      SEL_H_LO: if (XLEN == 64) h_d = wd64; else h_d[31:0] = wd64[31:0];
      SEL_H_HI: h_d[63:32] = wd64[31:0];
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q <= '0;
      h_q <= '0;
      s_q <= '0;
    end else if (we_i) begin
      if (sel_i == SEL_M_LO || sel_i == SEL_M_HI) m_q <= m_d & m_wmask;
      if (sel_i == SEL_H_LO || sel_i == SEL_H_HI) h_q <= h_d & H_WMASK;
      if (sel_i == SEL_S)                         s_q <= wd64[31:0] & S_WMASK;
    end
  end

  // lower tiers see the AND of every tier above them
  assign m_eff = m_q & ~(misa_f_i ? FCSR_BIT : 64'd0);
  generate
    if (HYP) begin : g_hyp
      assign h_eff = h_q & m_eff;
      assign s_eff = s_q & m_eff[31:0] & h_eff[31:0];
    end else begin : g_nohyp
      assign h_eff = '0;
      assign s_eff = s_q & m_eff[31:0];
    end
  endgenerate

  always_comb begin
    case (sel_i)
      SEL_M_LO: rd64 = m_eff;
      SEL_M_HI: rd64 = {32'd0, m_eff[63:32]};
      SEL_H_LO: rd64 = h_eff;
      SEL_H_HI: rd64 = {32'd0, h_eff[63:32]};
      SEL_S:    rd64 = {32'd0, s_eff};
      default:  rd64 = '0;
    endcase
  end

  assign rdata_o  = rd64[XLEN-1:0];
  assign m_se0_o  = m_eff[BIT_SE0];
  assign h_se0_o  = h_q[BIT_SE0];
  assign m_gate_o = pick_gates(m_eff);
  assign h_gate_o = pick_gates(h_eff);
  assign s_low_o  = s_q[2:0];

  assert_wmask_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((m_q & ~M_WMASK) == 64'd0) && ((h_q & ~H_WMASK) == 64'd0) && ((s_q & ~S_WMASK) == 32'd0));

  assert_tier_and_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((h_eff & ~m_eff) == 64'd0) && ((s_eff & ~m_eff[31:0]) == 32'd0));

  assert_fcsr_ro_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && misa_f_i && sel_i == SEL_M_LO) |=> !m_q[BIT_FCSR]);
endmodule

// File: rtl/stateen_levels.sv
`timescale 1ns/1ps
module stateen_levels
  import stateen_pkg::*;
#(
  parameter int HAS_H = 1
) (
  input  logic [1:0] priv_i,
  input  logic       virt_i,
  input  logic       misa_f_i,
  input  gate_t      m_gate_i,
  input  gate_t      h_gate_i,
  input  logic [2:0] s_low_i,
  output gate_t      en_o,
  output logic       fp_illegal_o,
  output logic       fp_virtual_o
);
  logic is_m, vmode, fp_fault, fp_vkind;

  assign is_m  = (priv_i == PRIV_M);
  assign vmode = (HAS_H != 0) && virt_i && !is_m;

  always_comb begin
    if (is_m) en_o = '1;
    else begin
      en_o = vmode ? h_gate_i : m_gate_i;
      if (priv_i == PRIV_U) begin
        en_o.custom = en_o.custom & s_low_i[0];
        en_o.fcsr   = en_o.fcsr   & s_low_i[1];
        en_o.jvt    = en_o.jvt    & s_low_i[2];
      end
    end
  end

  assign fp_fault     = !misa_f_i && !en_o.fcsr && !is_m;
  assign fp_vkind     = vmode && m_gate_i.fcsr && !h_gate_i.fcsr;
  assign fp_illegal_o = fp_fault && !fp_vkind;
  assign fp_virtual_o = fp_fault && fp_vkind;
endmodule

// File: rtl/stateen_gate.sv
`timescale 1ns/1ps
module stateen_gate
  import stateen_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int HAS_H = 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            csr_valid_i,
  input  logic            csr_we_i,
  input  logic [11:0]     csr_addr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  input  logic [1:0]      priv_i,
  input  logic            virt_i,
  input  logic            misa_f_i,
  output logic            csr_hit_o,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            csr_illegal_o,
  output logic            csr_virtual_o,
  output logic            en_custom_o,
  output logic            en_fcsr_o,
  output logic            en_jvt_o,
  output logic            en_envcfg_o,
  output logic            en_csrind_o,
  output logic            en_imsic_o,
  output logic            en_aia_o,
  output logic            en_context_o,
  output logic            fp_illegal_o,
  output logic            fp_virtual_o
);
  sel_e            sel;
  logic            m_se0, h_se0, ok, we;
  logic [XLEN-1:0] rd;
  gate_t           m_gate, h_gate, en;
  logic [2:0]      s_low;

  stateen_decode #(.XLEN(XLEN), .HAS_H(HAS_H)) u_decode (
    .valid_i(csr_valid_i), .addr_i(csr_addr_i), .priv_i(priv_i), .virt_i(virt_i),
    .m_se0_i(m_se0), .h_se0_i(h_se0), .sel_o(sel), .hit_o(csr_hit_o),
    .illegal_o(csr_illegal_o), .virtual_o(csr_virtual_o)
  );

  assign ok = csr_hit_o && !csr_illegal_o && !csr_virtual_o;
  assign we = ok && csr_we_i;

  stateen_regs #(.XLEN(XLEN), .HAS_H(HAS_H)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we), .sel_i(sel), .wdata_i(csr_wdata_i),
    .misa_f_i(misa_f_i), .rdata_o(rd), .m_se0_o(m_se0), .h_se0_o(h_se0),
    .m_gate_o(m_gate), .h_gate_o(h_gate), .s_low_o(s_low)
  );

  stateen_levels #(.HAS_H(HAS_H)) u_levels (
    .priv_i(priv_i), .virt_i(virt_i), .misa_f_i(misa_f_i), .m_gate_i(m_gate),
    .h_gate_i(h_gate), .s_low_i(s_low), .en_o(en),
    .fp_illegal_o(fp_illegal_o), .fp_virtual_o(fp_virtual_o)
  );

  assign csr_rdata_o  = ok ? rd : '0;
  assign en_custom_o  = en.custom;
  assign en_fcsr_o    = en.fcsr;
  assign en_jvt_o     = en.jvt;
  assign en_envcfg_o  = en.envcfg;
  assign en_csrind_o  = en.csrind;
  assign en_imsic_o   = en.imsic;
  assign en_aia_o     = en.aia;
  assign en_context_o = en.ctx;

  assert_miss_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_valid_i && !csr_hit_o) |-> (!csr_illegal_o && !csr_virtual_o && csr_rdata_o == '0));

  assert_m_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_valid_i && csr_addr_i == ADDR_M && priv_i != PRIV_M) |-> csr_illegal_o);

  assert_fault_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(csr_illegal_o && csr_virtual_o));

  assert_fp_kind_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_virtual_o |-> (virt_i && !fp_illegal_o && priv_i != PRIV_M));

  assert_mmode_open_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_i == PRIV_M) |-> (en == '1 && !fp_illegal_o && !fp_virtual_o));

  assert_no_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_valid_i && csr_we_i && (csr_illegal_o || csr_virtual_o)) |=>
      ($stable(u_regs.m_q) && $stable(u_regs.h_q) && $stable(u_regs.s_q)));
endmodule

// File: tb/stateen_gate_tb.sv
`timescale 1ns/1ps
module stateen_gate_tb;
  localparam logic [63:0] MM = 64'hDF00_0000_0000_0007;
  localparam logic [63:0] HM = 64'hDE00_0000_0000_0007;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        valid, we, virt, misa_f;
  logic [11:0] addr;
  logic [63:0] wdata;
  logic [1:0]  priv;
  logic        hit, ill, vf, fpi, fpv;
  logic [63:0] rdata;
  logic [7:0]  en_vec;
  logic e0, e1, e2, e3, e4, e5, e6, e7;

  logic        b_valid, b_we;
  logic [11:0] b_addr;
  logic [31:0] b_wdata, b_rdata;
  logic        b_hit, b_ill, b_vf;

  stateen_gate #(.XLEN(64), .HAS_H(1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .csr_valid_i(valid), .csr_we_i(we), .csr_addr_i(addr),
    .csr_wdata_i(wdata), .priv_i(priv), .virt_i(virt), .misa_f_i(misa_f),
    .csr_hit_o(hit), .csr_rdata_o(rdata), .csr_illegal_o(ill), .csr_virtual_o(vf),
    .en_custom_o(e0), .en_fcsr_o(e1), .en_jvt_o(e2), .en_envcfg_o(e3), .en_csrind_o(e4),
    .en_imsic_o(e5), .en_aia_o(e6), .en_context_o(e7),
    .fp_illegal_o(fpi), .fp_virtual_o(fpv)
  );
  assign en_vec = {e0, e1, e2, e3, e4, e5, e6, e7};

  stateen_gate #(.XLEN(32), .HAS_H(1)) u_dut32 (
    .clk_i(clk), .rst_ni(rst_n), .csr_valid_i(b_valid), .csr_we_i(b_we), .csr_addr_i(b_addr),
    .csr_wdata_i(b_wdata), .priv_i(2'b11), .virt_i(1'b0), .misa_f_i(1'b0),
    .csr_hit_o(b_hit), .csr_rdata_o(b_rdata), .csr_illegal_o(b_ill), .csr_virtual_o(b_vf),
    .en_custom_o(), .en_fcsr_o(), .en_jvt_o(), .en_envcfg_o(), .en_csrind_o(),
    .en_imsic_o(), .en_aia_o(), .en_context_o(), .fp_illegal_o(), .fp_virtual_o()
  );

  int n_cmp = 0, n_bad = 0;
  logic [63:0] sm = '0, sh = '0;
  logic [31:0] ss = '0;
  logic        r_hit, r_ill, r_vf;
  logic [63:0] r_rd;
  logic [31:0] r_rd32;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] mp(input int mode);
    case (mode) 0: mp = 2'b11; 1, 3: mp = 2'b01; default: mp = 2'b00; endcase
  endfunction

  task automatic op(input logic [11:0] a, input logic w, input logic [63:0] d, input int mode);
    @(negedge clk);
    valid = 1'b1; we = w; addr = a; wdata = d; priv = mp(mode); virt = (mode >= 3);
    #2;
    r_hit = hit; r_ill = ill; r_vf = vf; r_rd = rdata;
    @(posedge clk); #1;
    valid = 1'b0; we = 1'b0;
  endtask

  task automatic op32(input logic [11:0] a, input logic w, input logic [31:0] d);
    @(negedge clk);
    b_valid = 1'b1; b_we = w; b_addr = a; b_wdata = d;
    #2;
    r_rd32 = b_rdata;
    @(posedge clk); #1;
    b_valid = 1'b0; b_we = 1'b0;
  endtask

  function automatic logic [63:0] me(); me = sm & ~(misa_f ? 64'd2 : 64'd0); endfunction
  function automatic logic [63:0] he(); he = sh & me(); endfunction
  function automatic logic [31:0] se(); se = ss & me() & he(); endfunction

  task automatic mwr(input logic [63:0] v); op(12'h30C, 1'b1, v, 0); sm = v & MM & ~(misa_f ? 64'd2 : 64'd0); endtask
  task automatic hwr(input logic [63:0] v); op(12'h60C, 1'b1, v, 0); sh = v & HM; endtask
  task automatic swr(input logic [63:0] v); op(12'h10C, 1'b1, v, 0); ss = v[31:0] & 32'h7; endtask

  function automatic logic [63:0] pat(input int k);
    case (k) 0: pat = '1; 1: pat = '0; 2: pat = {16{4'hA}}; default: pat = {16{4'h5}}; endcase
  endfunction

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    valid = 0; we = 0; addr = '0; wdata = '0; priv = 2'b11; virt = 0; misa_f = 0;
    b_valid = 0; b_we = 0; b_addr = '0; b_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    op(12'h30C, 0, 0, 0); chk("R1 m reset", r_rd, 0);
    op(12'h60C, 0, 0, 0); chk("R1 h reset", r_rd, 0);
    op(12'h10C, 0, 0, 0); chk("R1 s reset", r_rd, 0);
    @(negedge clk); priv = 2'b01; virt = 0; #2;
    chk("R1 enables HS", {56'd0, en_vec}, 0);

    // R6: write masks, hypervisor bit 63 writable
    mwr('1); op(12'h30C, 0, 0, 0); chk("R6 m mask", r_rd, MM);
    hwr('1); op(12'h60C, 0, 0, 0); chk("R6 h mask", r_rd, HM & MM);
    swr('1); op(12'h10C, 0, 0, 0); chk("R6 s mask", r_rd, 64'h7);
    hwr(64'h8000_0000_0000_0000); op(12'h60C, 0, 0, 0); chk("R6 h bit63", r_rd, 64'h8000_0000_0000_0000);

    // R2: address decode
    op(12'h30D, 0, 0, 0); chk("R2 miss 30D", {r_hit, r_ill, r_vf}, 0); chk("R2 miss rd", r_rd, 0);
    op(12'h31C, 0, 0, 0); chk("R2 no hi on 64", {r_hit, r_ill, r_vf}, 0);
    op(12'h61C, 1, '1, 0); chk("R2 no hh on 64", {r_hit, r_ill, r_vf}, 0);

    // R3/R4/R5/R7: fault and read sweep
    for (int ms = 0; ms < 2; ms++) begin
      for (int hs = 0; hs < 2; hs++) begin
        mwr(MM & ~64'h8000_0000_0000_0000 | (64'(ms) << 63));
        hwr(HM & ~64'h8000_0000_0000_0000 | (64'(hs) << 63));
        swr(64'h7);
        for (int t = 0; t < 3; t++) begin
          for (int mode = 0; mode < 5; mode++) begin
            logic ei, ev;
            logic [63:0] er;
            ei = 0; ev = 0;
            if (t == 0) ei = (mode != 0);
            else if (mode == 0) ei = 0;
            else if (mode == 1) ei = (ms == 0);
            else if (mode == 2) ei = 1;
            else if (ms == 0) ei = 1;
            else if (t == 1) ev = 1;
            else if (mode == 3) ev = (hs == 0);
            else ev = 1;
            er = (t == 0) ? me() : (t == 1) ? he() : {32'd0, se()};
            op((t == 0) ? 12'h30C : (t == 1) ? 12'h60C : 12'h10C, 0, 0, mode);
            chk($sformatf("R3 R4 illegal t%0d m%0d se%0d%0d", t, mode, ms, hs), r_ill, ei);
            chk($sformatf("R5 virtual t%0d m%0d se%0d%0d", t, mode, ms, hs), r_vf, ev);
            chk($sformatf("R7 rdata t%0d m%0d se%0d%0d", t, mode, ms, hs), r_rd, (ei || ev) ? 64'd0 : er);
          end
        end
      end
    end

    // R7: lower-tier write then tier AND
    mwr(64'h8000_0000_0000_0003); hwr(HM);
    op(12'h10C, 1, 64'h5, 1); ss = 32'h5;
    op(12'h10C, 0, 0, 0); chk("R7 s and m", r_rd, 64'h1);
    op(12'h60C, 0, 0, 0); chk("R7 h and m", r_rd, 64'h8000_0000_0000_0003);

    // R11: faulted writes
    op(12'h30C, 1, '1, 2); chk("R11 fault rd", r_rd, 0);
    op(12'h30C, 0, 0, 0); chk("R11 m unchanged", r_rd, me());
    hwr(64'h7);
    op(12'h10C, 1, 64'h0, 3); chk("R11 vs blocked", r_vf, 1);
    op(12'h10C, 0, 0, 0); chk("R11 s unchanged", r_rd, {32'd0, se()});

    // R8: fcsr read-only zero under misa_f
    @(negedge clk); misa_f = 1;
    mwr('1); hwr('1); swr('1);
    op(12'h30C, 0, 0, 0); chk("R8 m fcsr", r_rd, MM & ~64'd2);
    op(12'h10C, 0, 0, 0); chk("R8 s fcsr", r_rd, 64'h5);
    @(negedge clk); priv = 2'b00; virt = 0; #2;
    chk("R9 no fp fault with misa_f", {fpi, fpv}, 0);
    @(negedge clk); misa_f = 0;
    op(12'h30C, 0, 0, 0); chk("R8 stays clear", r_rd, MM & ~64'd2);
    mwr('1); op(12'h30C, 0, 0, 0); chk("R8 writable again", r_rd, MM);

    // R9/R10: enable and fp fault sweep
    for (int pm = 0; pm < 4; pm++) begin
      for (int ph = 0; ph < 4; ph++) begin
        for (int ps = 0; ps < 2; ps++) begin
          mwr(pat(pm)); hwr(pat(ph)); swr(pat(ps + 2));
          for (int mode = 0; mode < 5; mode++) begin
            logic [63:0] l;
            logic [7:0] ee;
            logic flt, vk;
            if (mode == 0) l = '1;
            else if (mode >= 3) l = he();
            else l = me();
            if (mode == 2 || mode == 4) l[2:0] = l[2:0] & ss[2:0];
            ee = {l[0], l[1], l[2], l[62], l[60], l[58], l[59], l[57]};
            flt = (mode != 0) && !l[1];
            vk = (mode >= 3) && me()[1] && !he()[1];
            @(negedge clk); priv = mp(mode); virt = (mode >= 3); #2;
            chk($sformatf("R10 en p%0d%0d%0d m%0d", pm, ph, ps, mode), {56'd0, en_vec}, {56'd0, ee});
            chk($sformatf("R9 fp p%0d%0d%0d m%0d", pm, ph, ps, mode), {fpi, fpv}, {flt && !vk, flt && vk});
          end
        end
      end
    end

    // R12: 32-bit halves
    op32(12'h30C, 1, 32'hFFFF_FFFF); op32(12'h30C, 0, 0); chk("R12 m lo", r_rd32, 32'h7);
    op32(12'h31C, 0, 0); chk("R12 m hi before", r_rd32, 32'h0);
    op32(12'h31C, 1, 32'hFFFF_FFFF); op32(12'h31C, 0, 0); chk("R12 m hi", r_rd32, 32'hDF00_0000);
    op32(12'h30C, 0, 0); chk("R12 m lo kept", r_rd32, 32'h7);
    op32(12'h61C, 1, 32'hFFFF_FFFF); op32(12'h61C, 0, 0); chk("R12 h hi", r_rd32, 32'hDE00_0000);
    op32(12'h60C, 0, 0); chk("R12 h lo", r_rd32, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule